// File: doc/BRIEF.md
# Single/Double Floating-Point Load-Store Format Converter

This block sits on the memory path of a floating-point unit. It converts between the 32-bit single-precision memory format and the 64-bit double-precision register format. A load widens a single into a double. A store narrows a double that was itself widened from a single back into a 32-bit word. A raw move carries a 32-bit word through untouched, for integer data held in floating-point registers.

Every operand is classified. On widening, subnormal singles are normalized. Signalling NaNs are made quiet on both conversion paths, and their payload bits are kept. Which value of the top fraction bit marks a NaN as quiet is set by a parameter.

A signalling NaN on a conversion sets a sticky invalid-operation flag. Results come out one cycle after acceptance, behind a valid/ready handshake. Rounding is not needed, because every narrowed operand is exactly representable as a single.

Top module: `fp_ls_convert`

## Requirements
- R1: `out_class` reports the operand class. 2'b00 means zero or normal, 2'b01 subnormal (exponent zero, fraction nonzero), 2'b10 infinity (exponent all ones, fraction zero) and 2'b11 NaN (exponent all ones, fraction nonzero). The operand is the low 32 bits for raw move and widen, and the full 64 bits for narrow. `out_snan` is high only for a signalling NaN.
- R2: Widening a zero, normal or infinite single keeps the sign. It adds 896 to a nonzero, non-all-ones exponent and maps exponent 0xFF to 0x7FF. The 23 fraction bits go in bits 51:29, and bits 28:0 are zero.
- R3: Widening a subnormal single normalizes it. The leading one is shifted out of the fraction, and the exponent becomes 896 minus the number of leading zeros in the 23-bit fraction.
- R4: Narrowing reverses R2 and R3. Widening any non-NaN single and then narrowing the result gives the original 32 bits exactly, including both zeros and all subnormals. The result sits in `out_data[31:0]`, with the upper 32 bits zero.
- R5: A signalling NaN on widen or narrow comes out quiet. Only the quiet bit changes: bit 51 for a double, bit 22 for a single. A quiet NaN passes through unchanged apart from the format change. With the default polarity, 0x7FAFD17C returns from a widen-then-narrow round trip as 0x7FEFD17C.
- R6: Parameter QUIET_ONE chooses the polarity: 1 means a set top fraction bit marks a quiet NaN, 0 means a clear one does. Quieting always drives that bit to its quiet value. If this would leave the fraction zero, the next lower bit is set so that the result stays a NaN.
- R7: Raw move (in_op 2'b00) returns `in_data[31:0]` bit-exact in `out_data[31:0]`, with zeros above, for every operand class. It never sets the invalid flag.
- R8: `flag_invalid` is set by a signalling NaN on widen or narrow, and never by a quiet NaN. It changes on the edge that loads the result. It stays set until `flag_clr` is high at a clock edge. When a set and a clear meet on the same edge, the set wins.
- R9: `in_ready` equals `!out_valid || out_ready`. The result of an accepted operation is valid on the next cycle. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R10: The opcode encoding is 2'b00 raw move, 2'b01 widen and 2'b10 narrow. Code 2'b11 behaves exactly as a raw move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 2 | Opcode (R10) |
| in_data | input | 64 | Operand; low 32 bits for raw move and widen |
| flag_clr | input | 1 | Synchronous clear of the invalid flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Widened double, or narrowed/moved single in bits 31:0 |
| out_class | output | 2 | Operand class (R1) |
| out_snan | output | 1 | Operand was a signalling NaN |
| flag_invalid | output | 1 | Sticky invalid-operation flag |

## Verification
Every fault in this block shows up on `out_data` in the cycle after the operand is accepted, because no state is carried between operations except the flag. A wrong leading-zero count or exponent offset shows in the widened word directly. It also breaks the round trip for that subnormal position, so the bench sweeps every leading-zero count and every exponent value, then runs mixed-class random words. A quiet-bit error shows as a second changed bit or an unchanged bit 22 after the round trip. A flag fault shows at the next read after a signalling or quiet NaN, or after a raw move.

// File: rtl/fcv_pkg.sv
package fcv_pkg;

   typedef enum logic [1:0] {
      OP_MOVE   = 2'b00,
      OP_WIDEN  = 2'b01,
      OP_NARROW = 2'b10,
      OP_MOVE2  = 2'b11
   } fcv_op_e;

   typedef enum logic [1:0] {
      CLS_ZN   = 2'b00,
      CLS_SUB  = 2'b01,
      CLS_INF  = 2'b10,
      CLS_NAN  = 2'b11
   } fcv_cls_e;

endpackage

// File: rtl/fcv_classify.sv
module fcv_classify
   import fcv_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter bit QUIET_ONE = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output fcv_cls_e              cls_o,
   output logic                  snan_o
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              exp_zero;
   logic              frac_nz;
   logic              sig_pol;

   assign exp_f    = word_i[EXP_W+FRAC_W-1 -: EXP_W];
   assign frac_f   = word_i[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign frac_nz  = |frac_f;

   generate
      if (QUIET_ONE) begin : g_q1
         assign sig_pol = ~frac_f[FRAC_W-1];
      end else begin : g_q0
         assign sig_pol = frac_f[FRAC_W-1];
      end
   endgenerate

   always_comb begin
      if (exp_ones)
         cls_o = frac_nz ? CLS_NAN : CLS_INF;
      else if (exp_zero && frac_nz)
         cls_o = CLS_SUB;
      else
         cls_o = CLS_ZN;
   end

   assign snan_o = exp_ones & frac_nz & sig_pol;

endmodule

// File: rtl/fcv_quiet.sv
module fcv_quiet #(
   parameter int FRAC_W    = 23,
   parameter bit QUIET_ONE = 1'b1
) (
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              en_i,
   output logic [FRAC_W-1:0] frac_o
);

   generate
      if (QUIET_ONE) begin : g_set
         assign frac_o = en_i ? {1'b1, frac_i[FRAC_W-2:0]} : frac_i;
      end else begin : g_clr
         logic rest_nz;
         assign rest_nz = |frac_i[FRAC_W-2:0];
         assign frac_o  = !en_i  ? frac_i :
                          rest_nz ? {1'b0, frac_i[FRAC_W-2:0]} :
                                    {2'b01, {(FRAC_W-2){1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/fcv_widen.sv
module fcv_widen #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit QUIET_ONE = 1'b1
) (
   input  logic [SP_EXP_W+SP_FRAC_W:0] sp_i,
   input  logic                        snan_i,
   output logic [DP_EXP_W+DP_FRAC_W:0] dp_o
);

   localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
   localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
   localparam int LZ_W      = $clog2(SP_FRAC_W + 1);

   logic                 sgn;
   logic [SP_EXP_W-1:0]  e_s;
   logic [SP_FRAC_W-1:0] f_s;
   logic [LZ_W-1:0]      lz;
   logic                 seen;
   logic [SP_FRAC_W-1:0] f_norm;
   logic [DP_EXP_W-1:0]  e_d;
   logic [DP_FRAC_W-1:0] f_wide;
   logic [DP_FRAC_W-1:0] f_q;

   assign sgn = sp_i[SP_EXP_W+SP_FRAC_W];
   assign e_s = sp_i[SP_EXP_W+SP_FRAC_W-1 -: SP_EXP_W];
   assign f_s = sp_i[SP_FRAC_W-1:0];

   // leading-zero count of the single fraction
   always_comb begin
      lz   = '0;
      seen = 1'b0;
      for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
         if (!seen) begin
            if (f_s[i]) seen = 1'b1;
            else        lz   = lz + LZ_W'(1);
         end
      end
   end

   assign f_norm = f_s << (lz + LZ_W'(1));

   always_comb begin
      if (&e_s) begin
         e_d    = '1;
         f_wide = {f_s, {PAD_W{1'b0}}};
      end else if (e_s == '0) begin
         if (f_s == '0) begin
            e_d    = '0;
            f_wide = '0;
         end else begin
            e_d    = DP_EXP_W'(BIAS_DIFF) - DP_EXP_W'(lz);
            f_wide = {f_norm, {PAD_W{1'b0}}};
         end
      end else begin
         e_d    = DP_EXP_W'(e_s) + DP_EXP_W'(BIAS_DIFF);
         f_wide = {f_s, {PAD_W{1'b0}}};
      end
   end

   fcv_quiet #(.FRAC_W(DP_FRAC_W), .QUIET_ONE(QUIET_ONE)) i_quiet (
      .frac_i (f_wide),
      .en_i   (snan_i),
      .frac_o (f_q)
   );

   assign dp_o = {sgn, e_d, f_q};

   // a normalized subnormal never lands on a reserved double exponent
   always_comb begin
      if (e_s == '0 && f_s != '0)
         AST_SUB_EXP_RANGE: assert (e_d != '0 && e_d != '1); // R3
   end

endmodule

// File: rtl/fcv_narrow.sv
module fcv_narrow #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit QUIET_ONE = 1'b1
) (
   input  logic [DP_EXP_W+DP_FRAC_W:0] dp_i,
   input  logic                        snan_i,
   output logic [SP_EXP_W+SP_FRAC_W:0] sp_o
);

   localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
   localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
   localparam int SP_EMAX   = (1 << SP_EXP_W) - 1;
   localparam int NORM_LO   = BIAS_DIFF + 1;
   localparam int NORM_HI   = BIAS_DIFF + SP_EMAX - 1;
   localparam int SUB_LO    = BIAS_DIFF - SP_FRAC_W + 1;
   localparam int SH_W      = $clog2(SP_FRAC_W + 2);

   logic                 sgn;
   logic [DP_EXP_W-1:0]  e_d;
   logic [DP_FRAC_W-1:0] f_d;
   logic [DP_FRAC_W-1:0] f_q;
   logic [SP_FRAC_W-1:0] f_top;
   logic                 low_nz;
   logic [SP_FRAC_W:0]   mant;
   logic [SP_FRAC_W:0]   mant_sh;
   logic [SH_W-1:0]      sh;
   logic [SP_EXP_W-1:0]  e_s;
   logic [SP_FRAC_W-1:0] f_s;
   int                   e_int;

   assign sgn   = dp_i[DP_EXP_W+DP_FRAC_W];
   assign e_d   = dp_i[DP_EXP_W+DP_FRAC_W-1 -: DP_EXP_W];
   assign f_d   = dp_i[DP_FRAC_W-1:0];
   assign e_int = int'(e_d);

   fcv_quiet #(.FRAC_W(DP_FRAC_W), .QUIET_ONE(QUIET_ONE)) i_quiet (
      .frac_i (f_d),
      .en_i   (snan_i),
      .frac_o (f_q)
   );

   assign f_top  = f_q[DP_FRAC_W-1 -: SP_FRAC_W];
   assign low_nz = |f_q[PAD_W-1:0];
   assign mant   = {1'b1, f_top};

   always_comb begin
      e_s     = '0;
      f_s     = '0;
      sh      = '0;
      mant_sh = '0;
      if (&e_d) begin
         e_s = '1;
         // keep a NaN a NaN when its payload lived only in the dropped bits
         f_s = (f_top == '0 && low_nz) ? {2'b01, {(SP_FRAC_W-2){1'b0}}} : f_top;
      end else if (e_int >= NORM_LO && e_int <= NORM_HI) begin
         e_s = SP_EXP_W'(e_int - BIAS_DIFF);
         f_s = f_top;
      end else if (e_int > NORM_HI) begin
         e_s = '1;
      end else if (e_int >= SUB_LO) begin
         sh      = SH_W'(NORM_LO - e_int);
         mant_sh = mant >> sh;
         f_s     = mant_sh[SP_FRAC_W-1:0];
      end
   end

   assign sp_o = {sgn, e_s, f_s};

endmodule

// File: rtl/fp_ls_convert.sv
module fp_ls_convert
   import fcv_pkg::*;
#(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit QUIET_ONE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [1:0]                   in_op,
   input  logic [DP_EXP_W+DP_FRAC_W:0]  in_data,
   input  logic                         flag_clr,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [DP_EXP_W+DP_FRAC_W:0]  out_data,
   output logic [1:0]                   out_class,
   output logic                         out_snan,
   output logic                         flag_invalid
);

   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;

   // elaboration-time parameter checks
   generate
      if (DP_EXP_W <= SP_EXP_W) begin : g_bad_exp
         $error("double exponent must be wider than single exponent");
      end
      if (DP_FRAC_W <= SP_FRAC_W) begin : g_bad_frac
         $error("double fraction must be wider than single fraction");
      end
      if (SP_FRAC_W < 3 || SP_EXP_W < 2) begin : g_bad_small
         $error("single format too narrow");
      end
   endgenerate

   fcv_op_e             op;
   logic                accept;
   logic [SP_W-1:0]     sp_word;
   fcv_cls_e            cls_sp;
   fcv_cls_e            cls_dp;
   logic                snan_sp;
   logic                snan_dp;
   logic [DP_W-1:0]     widened;
   logic [SP_W-1:0]     narrowed;
   logic [DP_W-1:0]     res_d;
   fcv_cls_e            cls_d;
   logic                snan_d;
   logic                raise;
   fcv_op_e             out_op;

   assign op       = fcv_op_e'(in_op);
   assign sp_word  = in_data[SP_W-1:0];
   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   fcv_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .QUIET_ONE(QUIET_ONE)) i_cls_sp (
      .word_i (sp_word),
      .cls_o  (cls_sp),
      .snan_o (snan_sp)
   );

   fcv_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .QUIET_ONE(QUIET_ONE)) i_cls_dp (
      .word_i (in_data),
      .cls_o  (cls_dp),
      .snan_o (snan_dp)
   );

   fcv_widen #(
      .SP_EXP_W (SP_EXP_W), .SP_FRAC_W (SP_FRAC_W),
      .DP_EXP_W (DP_EXP_W), .DP_FRAC_W (DP_FRAC_W),
      .QUIET_ONE(QUIET_ONE)
   ) i_widen (
      .sp_i   (sp_word),
      .snan_i (snan_sp),
      .dp_o   (widened)
   );

   fcv_narrow #(
      .SP_EXP_W (SP_EXP_W), .SP_FRAC_W (SP_FRAC_W),
      .DP_EXP_W (DP_EXP_W), .DP_FRAC_W (DP_FRAC_W),
      .QUIET_ONE(QUIET_ONE)
   ) i_narrow (
      .dp_i   (in_data),
      .snan_i (snan_dp),
      .sp_o   (narrowed)
   );

   always_comb begin
      unique case (op)
         OP_WIDEN: begin
            res_d  = widened;
            cls_d  = cls_sp;
            snan_d = snan_sp;
            raise  = snan_sp;
         end
         OP_NARROW: begin
            res_d  = {{(DP_W-SP_W){1'b0}}, narrowed};
            cls_d  = cls_dp;
            snan_d = snan_dp;
            raise  = snan_dp;
         end
         default: begin
            res_d  = {{(DP_W-SP_W){1'b0}}, sp_word};
            cls_d  = cls_sp;
            snan_d = snan_sp;
            raise  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_class <= CLS_ZN;
         out_snan  <= 1'b0;
         out_op    <= OP_MOVE;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_data  <= res_d;
         out_class <= cls_d;
         out_snan  <= snan_d;
         out_op    <= op;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_invalid <= 1'b0;
      else if (accept && raise)
         flag_invalid <= 1'b1;
      else if (flag_clr)
         flag_invalid <= 1'b0;
   end

   AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid); // R9

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid && !flag_clr |=> flag_invalid); // R8

   AST_MOVE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (op == OP_MOVE || op == OP_MOVE2) && !flag_invalid |=> !flag_invalid); // R7

   AST_SNAN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_snan |-> out_class == CLS_NAN); // R1

   AST_WIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_op == OP_WIDEN && out_class == CLS_NAN
      |-> out_data[DP_FRAC_W-1] == QUIET_ONE); // R5

   AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_op == OP_NARROW && out_class == CLS_NAN
      |-> out_data[SP_FRAC_W-1] == QUIET_ONE); // R5

endmodule

// File: tb/test_fp_ls_convert.sv
module test_fp_ls_convert;

   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [63:0] in_data = '0;
   logic        flag_clr = 1'b0;
   logic        out_ready = 1'b1;
   logic        in_ready, out_valid, out_snan, flag_invalid;
   logic [63:0] out_data;
   logic [1:0]  out_class;
   logic        a_in_ready, a_out_valid, a_out_snan, a_flag;
   logic [63:0] a_out_data;
   logic [1:0]  a_out_class;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   fp_ls_convert i_fp_ls_convert (
      .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_data, .flag_clr,
      .out_valid, .out_ready, .out_data, .out_class, .out_snan, .flag_invalid
   );

   fp_ls_convert #(.QUIET_ONE(1'b0)) i_fp_ls_convert_alt (
      .clk, .rst_n, .in_valid, .in_ready(a_in_ready), .in_op, .in_data, .flag_clr,
      .out_valid(a_out_valid), .out_ready, .out_data(a_out_data),
      .out_class(a_out_class), .out_snan(a_out_snan), .flag_invalid(a_flag)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [63:0] d, output logic [63:0] r);
      @(negedge clk);
      in_op = op; in_data = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 valid after accept", {63'b0, out_valid}, 64'd1);
      r = out_data;
   endtask

   task automatic clr_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   // expected widened value for the default polarity
   function automatic logic [63:0] widen_ref(input logic [31:0] w);
      logic [7:0]  e;
      logic [22:0] f;
      int p;
      e = w[30:23]; f = w[22:0];
      if (e == 8'hFF) begin
         if (f != 0) f[22] = 1'b1;
         return {w[31], 11'h7FF, f, 29'b0};
      end
      if (e == 0 && f == 0) return {w[31], 63'b0};
      if (e == 0) begin
         p = 22;
         while (!f[p]) p--;
         return {w[31], 11'(896 - (22 - p)), 23'(f << (23 - p)), 29'b0};
      end
      return {w[31], 11'(int'(e) + 896), f, 29'b0};
   endfunction

   function automatic logic [1:0] class_ref(input logic [31:0] w);
      if (w[30:23] == 8'hFF) return (w[22:0] != 0) ? 2'b11 : 2'b10;
      if (w[30:23] == 8'h00) return (w[22:0] != 0) ? 2'b01 : 2'b00;
      return 2'b00;
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] r, r2;
      logic [31:0] w, seed;
      logic        sig;
      logic [31:0] nan_ex [4];
      nan_ex[0] = 32'h7FAFD17C; nan_ex[1] = 32'h7FBB8DC1;
      nan_ex[2] = 32'h7F99E608; nan_ex[3] = 32'h7F812D46;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset out_valid", {63'b0, out_valid}, 64'd0);
      chk("R8 reset flag", {63'b0, flag_invalid}, 64'd0);
      chk("R9 reset in_ready", {63'b0, in_ready}, 64'd1);

      // R2 directed normals / infinities / zeros
      run_op(2'b01, 64'h3F800000, r); chk("R2 widen 1.0", r, 64'h3FF0000000000000);
      run_op(2'b01, 64'hFF800000, r); chk("R2 widen -inf", r, 64'hFFF0000000000000);
      chk("R1 class inf", {62'b0, out_class}, 64'd2);
      run_op(2'b01, 64'h80000000, r); chk("R2 widen -0", r, 64'h8000000000000000);
      // R3 smallest subnormal: 2^-149 -> exponent 1023-149
      run_op(2'b01, 64'h00000001, r); chk("R3 widen min sub", r, {1'b0, 11'd874, 52'd0});
      chk("R1 class sub", {62'b0, out_class}, 64'd1);

      // R5 the four signalling examples
      foreach (nan_ex[k]) begin
         clr_flag();
         run_op(2'b01, {32'b0, nan_ex[k]}, r);
         chk("R1 snan flag out", {63'b0, out_snan}, 64'd1);
         run_op(2'b10, r, r2);
         chk("R5 round trip snan", r2, {32'b0, nan_ex[k] | 32'h00400000});
         chk("R8 snan sets flag", {63'b0, flag_invalid}, 64'd1);
      end

      // R8 quiet NaN leaves flag clear
      clr_flag();
      run_op(2'b01, 64'h7FC12345, r);
      chk("R5 qnan widen", r, widen_ref(32'h7FC12345));
      chk("R8 qnan no flag", {63'b0, flag_invalid}, 64'd0);

      // R7 raw move of a signalling NaN and of a full 64-bit input
      run_op(2'b00, 64'hDEADBEEF7F812D46, r);
      chk("R7 raw exact", r, 64'h000000007F812D46);
      chk("R7 raw no flag", {63'b0, flag_invalid}, 64'd0);
      chk("R1 raw class", {62'b0, out_class, out_snan}, 64'd7);
      // R10 code 11 acts as raw move
      run_op(2'b11, 64'h123456787FAFD17C, r);
      chk("R10 op 11 raw", r, 64'h000000007FAFD17C);
      chk("R10 op 11 no flag", {63'b0, flag_invalid}, 64'd0);

      // R8 stickiness and set-over-clear
      run_op(2'b10, 64'h7FF0000020000000, r);
      chk("R8 narrow snan flag", {63'b0, flag_invalid}, 64'd1);
      chk("R5 narrow snan", r, 64'h7FC00001);
      run_op(2'b00, 64'h1, r);
      chk("R8 sticky", {63'b0, flag_invalid}, 64'd1);
      @(negedge clk);
      flag_clr = 1'b1; in_op = 2'b01; in_data = 64'h7F800001; in_valid = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0; in_valid = 1'b0;
      chk("R8 set wins over clear", {63'b0, flag_invalid}, 64'd1);
      clr_flag();
      chk("R8 clear", {63'b0, flag_invalid}, 64'd0);

      // R6 inverted polarity instance
      run_op(2'b01, 64'h7FC00000, r);
      chk("R6 q1 instance quiet", r, 64'h7FF8000000000000);
      chk("R6 q0 snan fill bit", a_out_data, 64'h7FF4000000000000);
      chk("R6 q0 flag", {63'b0, a_flag}, 64'd1);
      run_op(2'b10, 64'h7FF4000000000000, r);
      chk("R6 q0 narrow quiet", a_out_data, 64'h7FA00000);
      clr_flag();
      run_op(2'b01, 64'h7F800001, r);
      chk("R6 q0 quiet passes", a_out_data, 64'h7FF0000020000000);
      chk("R6 q0 no flag", {63'b0, a_flag}, 64'd0);

      // R3/R4 every subnormal leading-zero count
      for (int lz = 0; lz < 23; lz++) begin
         w = (32'h00400000 >> lz) | (32'h0005A5A5 >> (lz + 1));
         w[31] = lz[0];
         run_op(2'b01, {32'b0, w}, r);
         chk("R3 subnormal widen", r, widen_ref(w));
         run_op(2'b10, r, r2);
         chk("R4 subnormal round trip", r2, {32'b0, w});
      end

      // R2/R4 every exponent value
      for (int e = 0; e < 255; e++) begin
         w = {1'b0, 8'(e), 23'h2B3C4D};
         run_op(2'b01, {32'b0, w}, r);
         chk("R2 exponent sweep", r, widen_ref(w));
         run_op(2'b10, r, r2);
         chk("R4 exponent round trip", r2, {32'b0, w});
      end

      // random mixed-class round trips
      seed = 32'h1F2E3D4C;
      for (int i = 0; i < 2500; i++) begin
         seed = xs(seed);
         w = seed;
         if (i % 4 == 0) w[30:23] = 8'hFF;
         if (i % 4 == 1) w[30:23] = 8'h00;
         sig = (w[30:23] == 8'hFF) && (w[22:0] != 0) && !w[22];
         clr_flag();
         run_op(2'b01, {32'b0, w}, r);
         chk("R2 R3 R5 random widen", r, widen_ref(w));
         chk("R1 random class", {62'b0, out_class}, {62'b0, class_ref(w)});
         chk("R1 random snan", {63'b0, out_snan}, {63'b0, sig});
         run_op(2'b10, r, r2);
         chk("R4 R5 random round trip", r2, {32'b0, sig ? (w | 32'h00400000) : w});
         chk("R8 random flag", {63'b0, flag_invalid}, {63'b0, sig});
      end

      // R9 back-pressure
      @(negedge clk);
      out_ready = 1'b0; in_op = 2'b01; in_data = 64'h3F800000; in_valid = 1'b1;
      @(negedge clk);
      in_data = 64'h40000000;
      chk("R9 ready low when stalled", {63'b0, in_ready}, 64'd0);
      chk("R9 first result", out_data, 64'h3FF0000000000000);
      repeat (2) @(negedge clk);
      chk("R9 hold while stalled", out_data, 64'h3FF0000000000000);
      chk("R9 valid held", {63'b0, out_valid}, 64'd1);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 second result", out_data, 64'h4000000000000000);
      @(negedge clk);
      chk("R9 drains", {63'b0, out_valid}, 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule